// File: doc/BRIEF.md
# Resistance-to-Frequency Measurement Counter

This block turns the output of an external RC oscillator into a number that software can read. Software first measures the oscillator while it runs through a reference resistor, then while it runs through a sensor resistor. The ratio of the two counts then gives the sensor's relative resistance. Two enable outputs tell the analog side which resistor to switch into the oscillator while a measurement is in progress.

There are two measurement modes. In edge-count mode, every rising edge of the synchronized oscillator input increments a 16-bit counter while a gate is open. The gate is closed either by software or by a pulse from an interval timer. In period mode, the roles swap. The first rising edge of the oscillator opens the gate, and a fast internal reference tick is counted until the next rising edge closes it. This gives good resolution when the oscillator is slow. Software drives the block through a small nibble-wide register port: one configuration register, one command register, four count nibbles and a status nibble.

Top module: `rfm_counter`

## Requirements
- R1: After reset the count is 0, the status nibble reads 0, irq and ovf are low, and both enable outputs are low.
- R2: In edge-count mode with the gate open, each rising edge of osc_in increments the count by one. The increment appears about three clocks after the edge, because of the two-flop synchronizer and the edge detector. A stop command (write 1 to command bit 1 at address 1) closes the gate without raising irq, and the count then stays frozen.
- R3: With timer gating selected (configuration bit 1 at address 0), a one-cycle gate_expire pulse ends an edge-count measurement and raises irq. With timer gating cleared, gate_expire is ignored and the measurement stays busy.
- R4: In period mode (configuration bit 0 = 1), a start waits with the armed status bit set until the first rising edge of osc_in. It then counts ref_tick cycles up to and including the cycle of the next rising edge, returns to idle and raises irq. For an oscillator period of P clocks, the count is P when ref_tick is always high and P/4 when ref_tick is high one cycle in four.
- R5: A count at 0xFFFF that receives another increment stays at 0xFFFF and sets ovf. The ovf flag stays set until command bit 2 clears it, and that clear leaves the count unchanged.
- R6: A start command (command bit 0) clears the count, ovf and irq, and begins a new measurement in the configured mode. A start while armed re-arms, so the block again waits for the first edge.
- R7: A stop command aborts from the armed or counting state to idle without raising irq. Command bit 3 clears irq.
- R8: Reading address 0 returns the live low nibble and latches the whole count. Addresses 1 to 3 return nibbles 1 to 3 of that latched copy, so later increments do not show until address 0 is read again.
- R9: While a measurement is armed or counting, sel_ref is high when configuration bit 2 is 0 and sel_sense is high when it is 1. Both are low when idle.
- R10: Address 4 reads the status nibble {busy, irq, ovf, armed}, with busy in bit 3 and armed in bit 0. Unused addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| osc_in | input | 1 | External RC oscillator signal, asynchronous |
| ref_tick | input | 1 | Internal reference-frequency enable, one cycle per tick |
| gate_expire | input | 1 | One-cycle pulse from the interval timer |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address: 0 configuration, 1 command |
| wr_data | input | 4 | Write data |
| rd_en | input | 1 | Register read strobe (latches the count when the address is 0) |
| rd_addr | input | 3 | Read address: 0 to 3 count nibbles, 4 status |
| rd_data | output | 4 | Read data |
| irq | output | 1 | Measurement-complete interrupt, sticky |
| ovf | output | 1 | Counter overflow flag, sticky |
| sel_ref | output | 1 | Enable for the reference resistor path |
| sel_sense | output | 1 | Enable for the sensor resistor path |

## Verification
The hardest state to reach from the ports is counter saturation. The count has to go past 65535 increments, and edge-count mode would need that many oscillator pulses. The bench reaches it in period mode instead. It holds ref_tick high every cycle and opens the gate with one rising edge of osc_in. It then keeps osc_in low for about 70,000 clocks before the closing edge. That single long window drives the counter into saturation, so the sticky flag and its separate clear can then be checked against the frozen 0xFFFF value.

// File: rtl/rfm_pkg.sv
package rfm_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ARM  = 2'd1,
        ST_RUN  = 2'd2
    } rfm_state_e;

    typedef struct packed {
        logic sel_sense;
        logic use_timer;
        logic period_mode;
    } rfm_cfg_t;

    typedef struct packed {
        rfm_state_e st;
        rfm_cfg_t   cfg;
        logic       irq;
        logic       ovf;
    } rfm_ctl_t;

    localparam int WA_CFG = 0;
    localparam int WA_CMD = 1;

    localparam int CMD_START   = 0;
    localparam int CMD_STOP    = 1;
    localparam int CMD_CLR_OVF = 2;
    localparam int CMD_CLR_IRQ = 3;

endpackage

// File: rtl/rfm_edge_sync.sv
module rfm_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic rise
);

    typedef struct packed {
        logic [STAGES-1:0] chain;
        logic              prev;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d       = s_q;
        s_d.chain = {s_q.chain[STAGES-2:0], async_in};
        s_d.prev  = s_q.chain[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign rise = s_q.chain[STAGES-1] & ~s_q.prev;

endmodule

// File: rtl/rfm_count_core.sv
module rfm_count_core #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] cnt,
    output logic         ovf_hit
);

    localparam logic [W-1:0] MAXV = '1;

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d   = cnt_q;
        ovf_hit = 1'b0;
        if (clr) begin
            cnt_d = '0;
        end else if (inc) begin
            if (cnt_q == MAXV) ovf_hit = 1'b1;
            else               cnt_d   = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cnt = cnt_q;

endmodule

// File: rtl/rfm_readout.sv
module rfm_readout #(
    parameter int CNT_W  = 16,
    parameter int NIB_W  = 4,
    parameter int ADDR_W = 3,
    localparam int NIBS  = CNT_W / NIB_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [CNT_W-1:0]  cnt,
    input  logic [NIB_W-1:0]  status,
    output logic [NIB_W-1:0]  rd_data
);

    logic [CNT_W-1:0] snap_d, snap_q;
    logic [NIB_W-1:0] snap_nib [NIBS];

    for (genvar g = 0; g < NIBS; g++) begin : g_nib
        assign snap_nib[g] = snap_q[g*NIB_W +: NIB_W];
    end

    always_comb begin
        snap_d = snap_q;
        if (rd_en && rd_addr == '0) snap_d = cnt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) snap_q <= '0;
        else        snap_q <= snap_d;
    end

    always_comb begin
        rd_data = '0;
        if (rd_addr == '0) begin
            rd_data = cnt[NIB_W-1:0];
        end else if (rd_addr == ADDR_W'(NIBS)) begin
            rd_data = status;
        end else begin
            for (int i = 1; i < NIBS; i++) begin
                if (rd_addr == ADDR_W'(i)) rd_data = snap_nib[i];
            end
        end
    end

endmodule

// File: rtl/rfm_counter.sv
module rfm_counter
    import rfm_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int NIB_W       = 4,
    parameter int SYNC_STAGES = 2,
    localparam int NIBS       = CNT_W / NIB_W,
    localparam int ADDR_W     = $clog2(NIBS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              osc_in,
    input  logic              ref_tick,
    input  logic              gate_expire,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [NIB_W-1:0]  wr_data,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [NIB_W-1:0]  rd_data,
    output logic              irq,
    output logic              ovf,
    output logic              sel_ref,
    output logic              sel_sense
);

    rfm_ctl_t         c_d, c_q;
    logic             osc_rise;
    logic             inc, cnt_clr, ovf_hit;
    logic [CNT_W-1:0] cnt;
    logic             cfg_wr, cmd_wr;
    logic             start_cmd, stop_cmd, clr_ovf_cmd, clr_irq_cmd;
    logic             busy, armed;
    logic [NIB_W-1:0] status;

    rfm_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (osc_in),
        .rise     (osc_rise)
    );

    rfm_count_core #(.W(CNT_W)) u_core (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (cnt_clr),
        .inc     (inc),
        .cnt     (cnt),
        .ovf_hit (ovf_hit)
    );

    assign cfg_wr      = wr_en && (wr_addr == ADDR_W'(WA_CFG));
    assign cmd_wr      = wr_en && (wr_addr == ADDR_W'(WA_CMD));
    assign start_cmd   = cmd_wr && wr_data[CMD_START];
    assign stop_cmd    = cmd_wr && wr_data[CMD_STOP];
    assign clr_ovf_cmd = cmd_wr && wr_data[CMD_CLR_OVF];
    assign clr_irq_cmd = cmd_wr && wr_data[CMD_CLR_IRQ];

    always_comb begin
        logic gate_end;
        c_d      = c_q;
        inc      = 1'b0;
        cnt_clr  = 1'b0;
        gate_end = 1'b0;

        if (cfg_wr) c_d.cfg = rfm_cfg_t'(wr_data[2:0]);

        unique case (c_q.st)
            ST_ARM: begin
                if (osc_rise) c_d.st = ST_RUN;
            end
            ST_RUN: begin
                if (c_q.cfg.period_mode) begin
                    inc      = ref_tick;
                    gate_end = osc_rise;
                end else begin
                    inc      = osc_rise;
                    gate_end = c_q.cfg.use_timer && gate_expire;
                end
                if (gate_end) begin
                    c_d.st  = ST_IDLE;
                    c_d.irq = 1'b1;
                end
            end
            default: ;
        endcase

        if (ovf_hit)     c_d.ovf = 1'b1;
        if (clr_ovf_cmd) c_d.ovf = 1'b0;
        if (clr_irq_cmd) c_d.irq = 1'b0;
        if (stop_cmd)    c_d.st  = ST_IDLE;

        if (start_cmd) begin
            c_d.st  = c_q.cfg.period_mode ? ST_ARM : ST_RUN;
            c_d.ovf = 1'b0;
            c_d.irq = 1'b0;
            cnt_clr = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '{st: ST_IDLE, cfg: '0, irq: 1'b0, ovf: 1'b0};
        else        c_q <= c_d;
    end

    assign busy      = (c_q.st != ST_IDLE);
    assign armed     = (c_q.st == ST_ARM);
    assign irq       = c_q.irq;
    assign ovf       = c_q.ovf;
    assign sel_ref   = busy && !c_q.cfg.sel_sense;
    assign sel_sense = busy &&  c_q.cfg.sel_sense;
    assign status    = NIB_W'({busy, c_q.irq, c_q.ovf, armed});

    rfm_readout #(.CNT_W(CNT_W), .NIB_W(NIB_W), .ADDR_W(ADDR_W)) u_rd (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_en   (rd_en),
        .rd_addr (rd_addr),
        .cnt     (cnt),
        .status  (status),
        .rd_data (rd_data)
    );

endmodule

// File: rtl/rfm_checker.sv
module rfm_checker #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic             clr_ovf,
    input logic             busy,
    input logic             armed,
    input logic [CNT_W-1:0] cnt,
    input logic             ovf,
    input logic             irq,
    input logic             sel_ref,
    input logic             sel_sense
);

    localparam logic [CNT_W-1:0] MAXV = '1;

    a_r6_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (cnt == '0 && !ovf && !irq));

    a_r5_count_saturates: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == MAXV && !start) |=> cnt == MAXV);

    a_r5_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf && !start && !clr_ovf) |=> ovf);

    a_r2_idle_count_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> $stable(cnt));

    a_r7_irq_from_active: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(busy));

    a_r9_sel_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({sel_ref, sel_sense}));

    a_r9_sel_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!sel_ref && !sel_sense));

    a_r4_armed_is_busy: assert property (@(posedge clk) disable iff (!rst_n)
        armed |-> (busy && cnt == '0));

endmodule

bind rfm_counter rfm_checker #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start_cmd),
    .clr_ovf   (clr_ovf_cmd),
    .busy      (busy),
    .armed     (armed),
    .cnt       (cnt),
    .ovf       (ovf),
    .irq       (irq),
    .sel_ref   (sel_ref),
    .sel_sense (sel_sense)
);

// File: tb/sim_rfm_counter.sv
`timescale 1ns/1ps
module sim_rfm_counter;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       osc_in = 1'b0;
    logic       ref_tick = 1'b0;
    logic       gate_expire = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] wr_addr = '0;
    logic [3:0] wr_data = '0;
    logic       rd_en = 1'b0;
    logic [2:0] rd_addr = '0;
    logic [3:0] rd_data;
    logic       irq, ovf, sel_ref, sel_sense;

    int checks = 0;
    int fails  = 0;
    int ref_every = 1;
    int ref_phase = 0;

    always #4 clk = ~clk;

    rfm_counter u0 (
        .clk, .rst_n, .osc_in, .ref_tick, .gate_expire,
        .wr_en, .wr_addr, .wr_data, .rd_en, .rd_addr, .rd_data,
        .irq, .ovf, .sel_ref, .sel_sense
    );

    always @(negedge clk) begin
        ref_tick  <= (ref_phase == 0);
        ref_phase <= (ref_phase + 1 >= ref_every) ? 0 : ref_phase + 1;
    end

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        summary();
        $finish;
    end

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(logic [2:0] a, logic [3:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(logic [2:0] a, output logic [3:0] v);
        @(negedge clk);
        rd_en = 1'b1; rd_addr = a;
        #1 v = rd_data;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic rd_count(output logic [15:0] v);
        logic [3:0] n;
        rd(3'd0, n); v[3:0]   = n;
        rd(3'd1, n); v[7:4]   = n;
        rd(3'd2, n); v[11:8]  = n;
        rd(3'd3, n); v[15:12] = n;
    endtask

    task automatic pulses(int n, int hi, int lo);
        for (int i = 0; i < n; i++) begin
            @(negedge clk) osc_in = 1'b1;
            repeat (hi - 1) @(negedge clk);
            @(negedge clk) osc_in = 1'b0;
            repeat (lo - 1) @(negedge clk);
        end
    endtask

    task automatic t_reset();
        logic [15:0] c; logic [3:0] s;
        rd_count(c);
        chk("R1 count", c, 16'h0);
        rd(3'd4, s);
        chk("R1 status", s, 4'h0);
        chk("R1 flags", {irq, ovf, sel_ref, sel_sense}, 4'b0000);
    endtask

    task automatic t_edge_soft();
        logic [15:0] c; logic [3:0] s;
        wr(3'd0, 4'b0000);
        wr(3'd1, 4'b0001);
        chk("R9 sel_ref", {sel_ref, sel_sense}, 2'b10);
        pulses(9, 3, 3);
        idle(5);
        wr(3'd1, 4'b0010);
        rd_count(c);
        chk("R2 edge count", c, 16'd9);
        rd(3'd4, s);
        chk("R2 soft stop no irq", s, 4'h0);
        pulses(4, 3, 3);
        idle(5);
        rd_count(c);
        chk("R2 frozen after stop", c, 16'd9);
        chk("R9 idle sel low", {sel_ref, sel_sense}, 2'b00);
    endtask

    task automatic t_edge_timer();
        logic [15:0] c; logic [3:0] s;
        wr(3'd0, 4'b0000);
        wr(3'd1, 4'b0001);
        gate_expire = 1'b1; @(negedge clk); gate_expire = 1'b0;
        rd(3'd4, s);
        chk("R3 expire ignored without timer", s, 4'b1000);
        wr(3'd1, 4'b0010);
        wr(3'd0, 4'b0110);
        wr(3'd1, 4'b0001);
        chk("R9 sel_sense", {sel_ref, sel_sense}, 2'b01);
        pulses(7, 2, 4);
        idle(5);
        gate_expire = 1'b1; @(negedge clk); gate_expire = 1'b0;
        idle(1);
        rd_count(c);
        chk("R3 timer count", c, 16'd7);
        rd(3'd4, s);
        chk("R3 timer irq status", s, 4'b0100);
        chk("R3 irq pin", irq, 1'b1);
        wr(3'd1, 4'b1000);
        chk("R7 irq clear", irq, 1'b0);
    endtask

    task automatic t_period(int every, int expv, string tag);
        logic [15:0] c; logic [3:0] s;
        ref_every = every;
        wr(3'd0, 4'b0001);
        wr(3'd1, 4'b0001);
        rd(3'd4, s);
        chk({tag, " armed"}, s, 4'b1001);
        idle(6);
        pulses(1, 20, 20);
        pulses(1, 5, 5);
        idle(6);
        rd_count(c);
        chk({tag, " period count"}, c, expv);
        rd(3'd4, s);
        chk({tag, " done irq"}, s, 4'b0100);
        ref_every = 1;
    endtask

    task automatic t_overflow();
        logic [15:0] c; logic [3:0] s;
        ref_every = 1;
        wr(3'd0, 4'b0001);
        wr(3'd1, 4'b0001);
        pulses(1, 10, 70000);
        pulses(1, 5, 5);
        idle(6);
        rd_count(c);
        chk("R5 saturated", c, 16'hFFFF);
        chk("R5 ovf set", ovf, 1'b1);
        wr(3'd1, 4'b0100);
        chk("R5 ovf cleared", ovf, 1'b0);
        rd_count(c);
        chk("R5 count kept", c, 16'hFFFF);
    endtask

    task automatic t_restart();
        logic [15:0] c; logic [3:0] s;
        wr(3'd0, 4'b0001);
        wr(3'd1, 4'b0001);
        idle(3);
        wr(3'd1, 4'b0001);
        rd(3'd4, s);
        chk("R6 rearm", s, 4'b1001);
        rd_count(c);
        chk("R6 start clears", c, 16'h0);
        wr(3'd1, 4'b0010);
        rd(3'd4, s);
        chk("R7 abort armed", s, 4'h0);
    endtask

    task automatic t_snapshot();
        logic [15:0] c; logic [3:0] n;
        wr(3'd0, 4'b0000);
        wr(3'd1, 4'b0001);
        pulses(20, 2, 2);
        idle(5);
        rd(3'd0, n);
        chk("R8 live nib0", n, 4'h4);
        pulses(20, 2, 2);
        idle(5);
        rd(3'd1, n);
        chk("R8 snapshot nib1", n, 4'h1);
        rd(3'd0, n);
        chk("R8 new nib0", n, 4'h8);
        rd(3'd1, n);
        chk("R8 refreshed nib1", n, 4'h2);
        wr(3'd1, 4'b0010);
        rd(3'd5, n);
        chk("R10 unused addr", n, 4'h0);
    endtask

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(2);
        t_reset();
        t_edge_soft();
        t_edge_timer();
        t_period(1, 40, "R4");
        t_period(4, 10, "R4 div4");
        t_restart();
        t_snapshot();
        t_overflow();
        summary();
        $finish;
    end

endmodule